// File: doc/BRIEF.md
# Packet Capture Flow Controller

This block decides, one packet at a time, whether an incoming transport packet may enter the capture buffer. A packet is bounded by a start strobe and an end strobe. Each accepted packet sets a sticky completion flag. Software clears that flag once it has moved or processed the data. Two mode bits choose how the flag throttles later packets: it can be ignored, it can stop capture at once, or it can allow one more packet before capture stops. In this way data that has not yet been read is never overwritten unless the user asks for that.

The accept gate is high on every cycle of an accepted packet, from the start strobe up to and including the end strobe. The storage next to the block uses it as its write enable. A one-cycle interrupt pulse goes with each rise of the completion flag and can be masked. A wrapping counter records packets that were refused while capture was enabled.

Top module: `pkt_capture_gate`

## Requirements
- R1: The decision to accept a packet is taken only in the cycle where `pkt_sop` is high and no accepted packet is in progress. That packet is accepted only if `cap_en` is high in that cycle. When it is accepted, `accept` is high from that cycle through the cycle of `pkt_eop`, both included. When `cap_en` is low at a start, the packet is neither accepted nor counted as dropped.
- R2: Once a packet has been accepted, `accept` stays high until its end strobe, whatever `cap_en`, the mode bits or `flag_clr` do in the meantime.
- R3: `done_flag` rises in the cycle after the end strobe of an accepted packet. A `flag_clr` pulse clears it in the next cycle. If a set and a clear happen in the same cycle, the set wins.
- R4: `done_irq` is a one-cycle pulse in the same cycle as the flag update caused by an accepted packet end. It appears only when `irq_en` was high in the end cycle.
- R5: Mode `mode_cont`=1, `mode_frame`=0 (free-running) accepts every enabled packet, whatever the state of `done_flag`.
- R6: Mode `mode_cont`=0, `mode_frame`=1 (one-shot) refuses every start while the registered `done_flag` is set. A `flag_clr` in the same cycle as the start does not help.
- R7: Mode `mode_cont`=0, `mode_frame`=0 (one-ahead) accepts one packet that starts while `done_flag` is set. Capture halts after that packet unless `flag_clr` was pulsed at some point from its start cycle through its end cycle. A halt is released by any later `flag_clr`.
- R8: Mode `mode_cont`=1, `mode_frame`=1 is reserved and accepts no packet.
- R9: `drop_cnt` increments by one for each start decision that refuses a packet while `cap_en` is high. It wraps modulo 2^CNT_W.
- R10: After reset, `accept`, `done_flag` and `done_irq` are low and `drop_cnt` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_en | input | 1 | Capture enable, sampled at packet start |
| mode_cont | input | 1 | Mode bit: free-running when set alone |
| mode_frame | input | 1 | Mode bit: one-shot when set alone |
| irq_en | input | 1 | Interrupt mask, 1 = pulse allowed |
| pkt_sop | input | 1 | First cycle of a packet |
| pkt_eop | input | 1 | Last cycle of a packet |
| flag_clr | input | 1 | Software clear of the completion flag |
| accept | output | 1 | Write gate for the current packet cycle |
| done_flag | output | 1 | Sticky completion flag |
| done_irq | output | 1 | One-cycle completion interrupt |
| drop_cnt | output | CNT_W | Count of refused enabled packets |

## Verification
The bench walks a sequence of packets through all four modes while carrying the flag state from one packet to the next. It covers the one-ahead packet with and without a clear during it. A design that halted too early would refuse that packet, and a design that ignored the clear would stall. Directed cases place a clear on the end-strobe cycle, where a design that let the clear win would lose a completion. They also drop the enable in mid-packet, where a design that truncated the packet would cut the gate short. A clear in the start cycle of a one-shot packet would slip a packet through if the decision used the next flag value. The drop counter is taken past its wrap point, and a one-cycle packet with start and end together is sent.

// File: rtl/pkt_capture_gate.sv
module pkt_capture_gate #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic             mode_cont,
  input  logic             mode_frame,
  input  logic             irq_en,
  input  logic             pkt_sop,
  input  logic             pkt_eop,
  input  logic             flag_clr,
  output logic             accept,
  output logic             done_flag,
  output logic             done_irq,
  output logic [CNT_W-1:0] drop_cnt
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic busy;
  logic grace_q;
  logic clr_seen_q;
  logic halt_q;
  logic may_take;

  wire start    = pkt_sop && !busy;
  wire one_head = !mode_cont && !mode_frame;

  always_comb begin
    unique case ({mode_cont, mode_frame})
      2'b10:   may_take = 1'b1;
      2'b01:   may_take = !done_flag;
      2'b00:   may_take = !halt_q;
      default: may_take = 1'b0;
    endcase
  end

  wire take      = start && cap_en && may_take;
  wire refuse    = start && cap_en && !may_take;
  assign accept  = take || busy;
  wire pkt_end   = accept && pkt_eop;
  wire grace_now = take ? (one_head && done_flag) : grace_q;
  wire clr_now   = take ? flag_clr : (clr_seen_q || flag_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      grace_q    <= 1'b0;
      clr_seen_q <= 1'b0;
    end else begin
      if (take) begin
        busy       <= !pkt_eop;
        grace_q    <= one_head && done_flag;
        clr_seen_q <= flag_clr;
      end else begin
        if (busy && pkt_eop) busy <= 1'b0;
        if (busy && flag_clr) clr_seen_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q    <= 1'b0;
      done_flag <= 1'b0;
      done_irq  <= 1'b0;
      drop_cnt  <= '0;
    end else begin
      if (pkt_end && grace_now && !clr_now) halt_q <= 1'b1;
      else if (flag_clr)                    halt_q <= 1'b0;
      if (pkt_end)       done_flag <= 1'b1;
      else if (flag_clr) done_flag <= 1'b0;
      done_irq <= pkt_end && irq_en;
      if (refuse) drop_cnt <= drop_cnt + CNT_ONE;
    end
  end

  AST_NO_ENABLE_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_sop && !busy && !cap_en) |-> !accept); // R1

  AST_PACKET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !pkt_eop) |=> accept); // R2

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pkt_eop) |=> done_flag); // R3

  AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> done_flag); // R4

  AST_ONE_SHOT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_sop && !busy && !mode_cont && mode_frame && done_flag) |-> !accept); // R6

  AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_sop && !busy && mode_cont && mode_frame) |-> !accept); // R8

  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_sop && !busy && cap_en && !accept) |=> (drop_cnt == $past(drop_cnt) + CNT_ONE)); // R9

endmodule

// File: tb/test_pkt_capture_gate.sv
module test_pkt_capture_gate;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n, cap_en, mode_cont, mode_frame, irq_en, pkt_sop, pkt_eop, flag_clr;
  logic accept, done_flag, done_irq;
  logic [CNT_W-1:0] drop_cnt;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;
  logic [CNT_W-1:0] exp_drop = '0;

  always #5 clk = ~clk;

  pkt_capture_gate #(.CNT_W(CNT_W)) i_pkt_capture_gate (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .mode_cont(mode_cont),
    .mode_frame(mode_frame), .irq_en(irq_en), .pkt_sop(pkt_sop), .pkt_eop(pkt_eop),
    .flag_clr(flag_clr), .accept(accept), .done_flag(done_flag), .done_irq(done_irq),
    .drop_cnt(drop_cnt)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      summary();
    end
  end

  task automatic pulse_clr();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
  endtask

  task automatic send(input int len, input int clr_at, input int en_off_at,
                      output bit acc, output bit hold_ok, output bit flag_after,
                      output bit irq_now, output bit irq_next);
    hold_ok = 1'b1;
    acc = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      pkt_sop  = (i == 0);
      pkt_eop  = (i == len - 1);
      flag_clr = (i == clr_at);
      if (i == en_off_at) cap_en = 1'b0;
      #1;
      if (i == 0) acc = accept;
      else if (accept !== acc) hold_ok = 1'b0;
    end
    @(negedge clk);
    pkt_sop = 1'b0; pkt_eop = 1'b0; flag_clr = 1'b0;
    #1;
    flag_after = done_flag;
    irq_now = done_irq;
    @(negedge clk);
    #1;
    irq_next = done_irq;
  endtask

  // {cont, frame, en, clr_before, clr_during, exp_accept, exp_flag}
  localparam logic [6:0] VEC [16] = '{
    7'b1010011, 7'b1010011, 7'b0110001, 7'b0111011,
    7'b0110100, 7'b0110011, 7'b0010011, 7'b0010001,
    7'b0011011, 7'b0010111, 7'b0010011, 7'b0010001,
    7'b0000001, 7'b1111000, 7'b1000000, 7'b1010011
  };

  initial begin
    bit acc, hold, fl, irq0, irq1;
    rst_n = 1'b0; cap_en = 1'b0; mode_cont = 1'b0; mode_frame = 1'b0;
    irq_en = 1'b1; pkt_sop = 1'b0; pkt_eop = 1'b0; flag_clr = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R10 accept", accept, 0);
    check("R10 flag", done_flag, 0);
    check("R10 irq", done_irq, 0);
    check("R10 drop", drop_cnt, 0);
    @(negedge clk) rst_n = 1'b1;

    // R5 R6 R7 R8 R1 R9 across modes, flag state carried between rows
    for (int r = 0; r < 16; r++) begin
      logic [6:0] v;
      v = VEC[r];
      @(negedge clk);
      mode_cont = v[6]; mode_frame = v[5]; cap_en = v[4];
      if (v[3]) pulse_clr();
      send(3, v[2] ? 1 : -1, -1, acc, hold, fl, irq0, irq1);
      if (v[4] && !v[1]) exp_drop = exp_drop + 1'b1;
      check($sformatf("R5/R6/R7/R8 row %0d accept", r), acc, v[1]);
      check($sformatf("R2 row %0d held", r), hold, 1);
      check($sformatf("R3 row %0d flag", r), fl, v[0]);
      check($sformatf("R4 row %0d irq", r), irq0, v[1]);
      check($sformatf("R4 row %0d irq width", r), irq1, 0);
      check($sformatf("R9 row %0d drops", r), drop_cnt, exp_drop);
    end

    // R3: a clear on the end cycle loses to the set
    mode_cont = 1'b1; mode_frame = 1'b0; cap_en = 1'b1;
    pulse_clr();
    #1 check("R3 clear alone", done_flag, 0);
    send(3, 2, -1, acc, hold, fl, irq0, irq1);
    check("R3 set wins", fl, 1);

    // R4: masked interrupt
    irq_en = 1'b0;
    send(2, -1, -1, acc, hold, fl, irq0, irq1);
    check("R4 masked irq", irq0, 0);
    check("R4 masked flag", fl, 1);
    irq_en = 1'b1;

    // R2: enable dropped mid-packet
    cap_en = 1'b1;
    send(4, -1, 1, acc, hold, fl, irq0, irq1);
    check("R2 accepted", acc, 1);
    check("R2 held after enable low", hold, 1);
    cap_en = 1'b1;

    // R6: clear in start cycle does not admit a one-shot packet
    mode_cont = 1'b0; mode_frame = 1'b1;
    send(3, 0, -1, acc, hold, fl, irq0, irq1);
    exp_drop = exp_drop + 1'b1;
    check("R6 clear at start", acc, 0);
    check("R6 flag cleared", fl, 0);

    // R1: single-cycle packet
    send(1, -1, -1, acc, hold, fl, irq0, irq1);
    check("R1 one-cycle accept", acc, 1);
    check("R1 one-cycle flag", fl, 1);

    // R9: wrap of the drop counter in reserved mode
    mode_cont = 1'b1; mode_frame = 1'b1;
    for (int k = 0; k < (1 << CNT_W); k++) begin
      @(negedge clk) pkt_sop = 1'b1; pkt_eop = 1'b1;
      @(negedge clk) pkt_sop = 1'b0; pkt_eop = 1'b0;
    end
    #1 check("R9 wrap", drop_cnt, exp_drop);
    check("R8 no accept in reserved", done_flag, 1);

    summary();
  end
endmodule